// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register with Clock Inhibit

This block turns an 8-bit word into a serial bit stream. Driving the active-low load control low copies the parallel word straight into the stage chain. No clock edge is needed for this. While the control is held low, the chain keeps following the parallel inputs. The top stage's bit is visible on the serial output at once.

Once the load control returns high, each effective rising clock edge moves every stage one place toward the output. The stage at the far end is refilled from the serial input. The remaining seven word bits come out most significant first, followed by the serial-input bits in the order they were applied.

The effective clock is the OR of the clock and the clock-inhibit input. A high level on either one therefore freezes the chain against edges from the other. Either pin can serve as an active-low enable while the other acts as the clock. The inhibit input should only change while the clock is high. A rising inhibit while the clock is low is itself an effective edge.

A synchronous active-low reset clears the chain on an effective edge, but only while the load control is high. Loading has priority over reset.

Top module: `piso_shift_reg`

## Requirements
- R1: With rst_n low and sh_ld_n high, an effective rising edge clears all stages, so ser_out reads 0 afterwards even if the chain held all ones.
- R2: While sh_ld_n is low, the stages follow par_in with no clock edge, including changes of par_in made during the low period (also with the clock stopped).
- R3: While sh_ld_n is low, ser_out equals par_in[7] within the same time step.
- R4: With sh_ld_n high, each effective rising edge moves stage i to stage i+1. After k edges from the release of a load of word W, ser_out equals W[7-k] for k = 0..7.
- R5: On each shift edge the value of ser_in enters stage 0. The bit applied before edge j appears on ser_out after edge j+7.
- R6: While clk_inh is high, rising edges of clk do not change the chain. Shifting resumes at the first clk rising edge after clk_inh falls.
- R7: With clk held low, each rising edge of clk_inh is an effective edge and shifts the chain once.
- R8: After sh_ld_n rises, changes on par_in have no effect on the chain or ser_out.
- R9: Clock edges that arrive while sh_ld_n is low do not shift. The word present when sh_ld_n rises is the one shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active, ORed with clk_inh |
| clk_inh | input | 1 | Clock inhibit, high blocks edges of clk |
| rst_n | input | 1 | Synchronous active-low reset, taken on an effective edge |
| sh_ld_n | input | 1 | High: shift; low: transparent asynchronous load |
| par_in | input | 8 | Parallel word; bit 7 is shifted out first |
| ser_in | input | 1 | Serial fill bit for stage 0 |
| ser_out | output | 1 | Serial output, last stage (or par_in[7] while loading) |

## Verification
A wrong value in any stage reaches ser_out only after the edges needed to carry it to the last stage. A fault in stage i therefore shows up 7-i effective edges later. The bench follows every bit of two full 16-edge streams so that each stage position is observed. A load path fault is visible at once on ser_out while loading, or on the first bits after release. A gating fault shows as a bit advanced too early during inhibit, or as a missing shift when the inhibit pin acts as the clock.

// File: rtl/piso_pkg.sv
// Package: shared constants and control encoding for the serial-out register.
// Assumes: the load control is active low; the default word width is 8.
package piso_pkg;

    localparam int unsigned PISO_WIDTH_DEF = 8;

    // Decoded meaning of the shift/load control level.
    typedef enum logic {
        CTL_LOAD  = 1'b0,
        CTL_SHIFT = 1'b1
    } piso_ctl_e;

endpackage

// File: rtl/piso_clk_merge.sv
// Module: forms the effective clock as the OR of the two clock pins.
// Assumes: clk_inh only changes while clk is high, so no extra edge appears.
module piso_clk_merge (
    input  logic clk,
    input  logic clk_inh,
    output logic clk_eff
);

    // Either pin held high masks the rising edges of the other.
    assign clk_eff = clk | clk_inh;

endmodule

// File: rtl/piso_stage_cell.sv
// Module: one storage stage with transparent asynchronous load.
// The load is decoded into a set and a clear so that the stage follows
// par_bit at any time while loading. It shifts prev_bit in on clk_eff.
// Assumes: synchronous reset only acts when no load is active.
module piso_stage_cell (
    input  logic clk_eff,
    input  logic rst_n,
    input  logic ld_n,
    input  logic par_bit,
    input  logic prev_bit,
    output logic q
);

    logic set_a;
    logic clr_a;

    // Load decode: exactly one of set/clear is high while loading.
    assign set_a = ~ld_n & par_bit;
    assign clr_a = ~ld_n & ~par_bit;

    // Stage storage: async load wins, then sync reset, then shift.
    always_ff @(posedge clk_eff or posedge set_a or posedge clr_a) begin
        if (set_a) begin
            q <= 1'b1;
        end else if (clr_a) begin
            q <= 1'b0;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= prev_bit;
        end
    end

endmodule

// File: rtl/piso_out_sel.sv
// Module: serial output selector.
// While loading it passes the top parallel bit straight to the pin, so the
// output needs neither a clock nor the stage to settle. Otherwise it drives
// the last stage.
module piso_out_sel
    import piso_pkg::*;
(
    input  piso_ctl_e ctl,
    input  logic      top_par,
    input  logic      top_stage,
    output logic      ser_out
);

    // Output mux: bypass during load, last stage during shift.
    always_comb begin
        if (ctl == CTL_LOAD) begin
            ser_out = top_par;
        end else begin
            ser_out = top_stage;
        end
    end

endmodule

// File: rtl/piso_shift_reg.sv
// Module: parallel-load, serial-out shift register with clock inhibit.
// Stage WIDTH-1 drives the output. Stage 0 is refilled from ser_in.
// Assumes: clk_inh changes only while clk is high; rst_n is sampled on
// effective edges.
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = PISO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clk_inh,
    input  logic             rst_n,
    input  logic             sh_ld_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out
);

    localparam int unsigned TOP = WIDTH - 1;

    logic             clk_eff;
    logic [WIDTH-1:0] stage;
    logic [WIDTH-1:0] chain_in;
    piso_ctl_e        ctl;

    // Decode the control level into the shared encoding.
    assign ctl = piso_ctl_e'(sh_ld_n);

    piso_clk_merge u_clk_merge (
        .clk     (clk),
        .clk_inh (clk_inh),
        .clk_eff (clk_eff)
    );

    // Shift source of each stage: serial input for stage 0, neighbour otherwise.
    assign chain_in = {stage[WIDTH-2:0], ser_in};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        piso_stage_cell u_cell (
            .clk_eff  (clk_eff),
            .rst_n    (rst_n),
            .ld_n     (sh_ld_n),
            .par_bit  (par_in[i]),
            .prev_bit (chain_in[i]),
            .q        (stage[i])
        );
    end

    piso_out_sel u_out_sel (
        .ctl       (ctl),
        .top_par   (par_in[TOP]),
        .top_stage (stage[TOP]),
        .ser_out   (ser_out)
    );

endmodule

// File: rtl/piso_shift_reg_chk.sv
// Checker: properties for the serial-out register, bound to the top module.
// Assumes: inputs change away from clock edges.
module piso_shift_reg_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             clk_inh,
    input logic             clk_eff,
    input logic             rst_n,
    input logic             sh_ld_n,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stage
);

    logic load_seen;

    // Marks an effective-clock interval in which a load occurred.
    always_ff @(posedge clk_eff or negedge sh_ld_n) begin
        if (!sh_ld_n) begin
            load_seen <= 1'b1;
        end else begin
            load_seen <= 1'b0;
        end
    end

    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_ld_n |-> stage == par_in); // R2

    AST_SHIFT_MOVE: assert property (@(posedge clk_eff) disable iff (!rst_n)
        sh_ld_n |=> (load_seen || stage[WIDTH-1:1] == $past(stage[WIDTH-2:0]))); // R4

    AST_SERIAL_FILL: assert property (@(posedge clk_eff) disable iff (!rst_n)
        sh_ld_n |=> (load_seen || stage[0] == $past(ser_in))); // R5

    AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_inh && $past(clk_inh) && sh_ld_n && $past(sh_ld_n)) |-> $stable(stage)); // R6

endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .clk_inh (clk_inh),
    .clk_eff (clk_eff),
    .rst_n   (rst_n),
    .sh_ld_n (sh_ld_n),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .stage   (stage)
);

// File: tb/test_piso_shift_reg.sv
`timescale 1ns/100ps
module test_piso_shift_reg;

    logic       clk     = 1'b0;
    logic       clk_en  = 1'b1;
    logic       clk_inh = 1'b0;
    logic       rst_n   = 1'b0;
    logic       sh_ld_n = 1'b1;
    logic       ser_in  = 1'b0;
    logic [7:0] par_in  = 8'h00;
    logic       ser_out;

    int n_checks = 0;
    int n_fail   = 0;

    piso_shift_reg i_piso_shift_reg (
        .clk     (clk),
        .clk_inh (clk_inh),
        .rst_n   (rst_n),
        .sh_ld_n (sh_ld_n),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .ser_out (ser_out)
    );

    // 200 MHz clock, held low when clk_en is cleared.
    initial begin
        forever begin
            #2.5;
            if (clk_en) clk = ~clk;
            else        clk = 1'b0;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Load W (raising sh_ld_n at a falling clock edge), then check 16 output bits.
    task automatic shift_check(input string req, input logic [7:0] w, input logic [7:0] fill);
        for (int m = 0; m < 16; m++) begin
            check(req, ser_out, (m < 8) ? w[7-m] : fill[15-m], $sformatf("stream bit %0d", m));
            ser_in = (m < 8) ? fill[7-m] : 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        sh_ld_n = 1'b0;
        par_in  = 8'hFF;
        #1;
        sh_ld_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", ser_out, 1'b0, "after reset edge");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ser_out, 1'b0, "zero after release");
    endtask

    task automatic t_load_follow();
        @(negedge clk);
        sh_ld_n = 1'b0;
        par_in  = 8'hA5;
        #1 check("R3", ser_out, 1'b1, "msb visible on load");
        par_in = 8'h3C;
        #1 check("R3", ser_out, 1'b0, "follows new msb");
        repeat (3) @(negedge clk);
        check("R9", ser_out, 1'b0, "no shift while loading");
        par_in = 8'hB2;
        #1 check("R2", ser_out, 1'b1, "follows late change");
        @(negedge clk);
        sh_ld_n = 1'b1;
        shift_check("R4_R5", 8'hB2, 8'h6D);
    endtask

    task automatic t_second_word();
        @(negedge clk);
        sh_ld_n = 1'b0;
        par_in  = 8'h4E;
        @(negedge clk);
        sh_ld_n = 1'b1;
        shift_check("R4_R5", 8'h4E, 8'hF0);
    endtask

    task automatic t_inhibit();
        logic [7:0] w;
        w = 8'h5A;
        @(negedge clk);
        sh_ld_n = 1'b0;
        par_in  = w;
        @(negedge clk);
        sh_ld_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R4", ser_out, w[5], "before inhibit");
        @(posedge clk);
        #1 clk_inh = 1'b1;
        for (int k = 0; k < 6; k++) begin
            ser_in = k[0];
            @(negedge clk);
            check("R6", ser_out, w[4], "frozen by inhibit");
        end
        @(posedge clk);
        #1 clk_inh = 1'b0;
        @(negedge clk);
        check("R6", ser_out, w[4], "no edge on inhibit release");
        @(negedge clk);
        check("R6", ser_out, w[3], "shift resumes");
    endtask

    task automatic t_inh_as_clock();
        logic [7:0] w;
        w = 8'hC6;
        ser_in = 1'b0;
        @(negedge clk);
        clk_en = 1'b0;
        #3;
        sh_ld_n = 1'b0;
        par_in  = w;
        #2 sh_ld_n = 1'b1;
        #2 check("R2", ser_out, w[7], "load with clock stopped");
        for (int k = 1; k <= 3; k++) begin
            clk_inh = 1'b1;
            #2 clk_inh = 1'b0;
            #2 check("R7", ser_out, w[7-k], $sformatf("inhibit pulse %0d", k));
        end
        clk_en = 1'b1;
        @(negedge clk);
        check("R7", ser_out, w[3], "clock resumed");
    endtask

    task automatic t_late_data();
        @(negedge clk);
        sh_ld_n = 1'b0;
        par_in  = 8'h81;
        @(negedge clk);
        sh_ld_n = 1'b1;
        #1 par_in = 8'h7E;
        #1 check("R8", ser_out, 1'b1, "par_in ignored after release");
        @(negedge clk);
        check("R8", ser_out, 1'b0, "second bit from loaded word");
        for (int k = 0; k < 6; k++) @(negedge clk);
        check("R8", ser_out, 1'b1, "last loaded bit");
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        t_load_follow();
        t_second_word();
        t_inhibit();
        t_inh_as_clock();
        t_late_data();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule